// File: doc/BRIEF.md
# Channel-Mapped Prioritized Interrupt Controller

This block collects up to 64 interrupt sources and presents them to a processor as two host lines: a fast line and a normal line. Each source is conditioned by a per-source polarity bit and a per-source trigger-kind bit, which select rising edge, falling edge, active-high level or active-low level. The result lands in a status bit. A source is pending when its status bit and its enable bit are both set.

Each source is routed to one of 32 channels through a byte-wide map field. The channel number is the priority, and channel 0 is the most urgent. Channels 0 and 1 feed the fast line and channels 2 to 31 feed the normal line. Software reads a single word that names the most urgent pending source, or that flags that nothing is pending.

Software reaches the block through a simple synchronous bus with a byte address, write data, a write strobe, a read strobe and registered read data. There are single-index set and clear words for the enables, a single-index clear word for status, bulk write-one-to-clear words for status and enables, and plain read/write words for polarity, trigger kind, channel map, host enables and a global enable. Register decode is a named selector, with one state per region: `SEL_NONE`, `SEL_GLB`, `SEL_STAT_ICLR`, `SEL_EN_ISET`, `SEL_EN_ICLR`, `SEL_HEN_ISET`, `SEL_HEN_ICLR`, `SEL_PRIO`, `SEL_STAT_BULK`, `SEL_EN_BULK`, `SEL_CHMAP`, `SEL_POL`, `SEL_TYPE` and `SEL_HEN`. The selector moves between these states only as the bus address changes, and every selector state falls back to `SEL_NONE` for an unmapped address.

Top module: `cpic_intc`

## Requirements
- R1: After reset, every register reads zero. Both host lines are low, and the prioritized word reads 0x8000_0000.
- R2: A write of value k to 0x28 sets enable bit k, and a write of k to 0x2C clears it. Values of NUM_SRC or more change nothing. Enable word n is read at 0x380+4n, where bit b belongs to source 32n+b.
- R3: Writing a word to 0x380+4n clears the enable of source 32n+b for every bit b written as 1. Bits written as 0 are untouched.
- R4: An edge source (trigger-kind bit 1) sets its status on its selected edge: rising when the polarity bit is 1, falling when it is 0. Status then holds until it is cleared, either by a write of k to 0x24 or by a 1 in bit b of 0x280+4n. Status word n reads at 0x280+4n. When a new edge and a clear coincide, the new edge wins.
- R5: A level source (trigger-kind bit 0) has status equal to the input one clock earlier. The input is active high when the polarity bit is 1 and active low when it is 0. A status clear has no lasting effect while the input is active.
- R6: Polarity word n sits at 0xD00+4n and trigger-kind word n at 0xD80+4n. Both are read/write, with bit b belonging to source 32n+b.
- R7: Map word n sits at 0x400+4n. Bits 8j+4:8j hold the channel of source 4n+j. The upper three bits of each byte are dropped and read back as zero.
- R8: Bits 9:0 of the word at 0x80 give the pending source with the lowest channel number. Among pending sources that share that channel, the lowest source number wins. Disabled sources are never chosen.
- R9: Bit 31 of the word at 0x80 is 1 exactly when no source is pending, and bits 30:0 are then zero.
- R10: The fast line is high when the global enable, host enable bit 0, and a pending source on channel 0 or 1 are all present. The normal line does the same with host enable bit 1 and channels 2 to 31. Host enables are written as a word at 0x1500, or one at a time through 0x34 (set) and 0x38 (clear) with index 0 or 1.
- R11: While bit 0 of the global enable word at 0x10 is 0, both host lines stay low, whatever is pending.
- R12: Reads of unmapped addresses return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address, low two bits ignored |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| src_i | input | NUM_SRC | Interrupt source inputs, synchronous to clk |
| fiq_o | output | 1 | Fast host interrupt line |
| irq_o | output | 1 | Normal host interrupt line |

## Verification
The hardest situations to reach are edge capture and priority ties. An edge source must see its input cross in the right direction after its trigger kind is set. A level source held active must be cleared while it stays active. The stimulus first programs polarity and trigger kind, then toggles a falling-edge source high and back low so that the conditioned input really rises. It also issues the status clear of a level source while that input is still held active. Ties are forced by mapping two sources to one channel and leaving a third source on a lower-priority channel. Enables are then removed one at a time, so the winner moves from the tie to its partner and then to the third source.

// File: rtl/cpic_pkg.sv
package cpic_pkg;

    localparam logic [31:0] OFF_GLB       = 32'h0000_0010;
    localparam logic [31:0] OFF_STAT_ICLR = 32'h0000_0024;
    localparam logic [31:0] OFF_EN_ISET   = 32'h0000_0028;
    localparam logic [31:0] OFF_EN_ICLR   = 32'h0000_002C;
    localparam logic [31:0] OFF_HEN_ISET  = 32'h0000_0034;
    localparam logic [31:0] OFF_HEN_ICLR  = 32'h0000_0038;
    localparam logic [31:0] OFF_PRIO      = 32'h0000_0080;
    localparam logic [31:0] OFF_STAT_BULK = 32'h0000_0280;
    localparam logic [31:0] OFF_EN_BULK   = 32'h0000_0380;
    localparam logic [31:0] OFF_CHMAP     = 32'h0000_0400;
    localparam logic [31:0] OFF_POL       = 32'h0000_0D00;
    localparam logic [31:0] OFF_TYPE      = 32'h0000_0D80;
    localparam logic [31:0] OFF_HEN       = 32'h0000_1500;

    localparam int FAST_CHANNELS = 2;
    localparam int HOST_LINES    = 2;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_GLB,
        SEL_STAT_ICLR,
        SEL_EN_ISET,
        SEL_EN_ICLR,
        SEL_HEN_ISET,
        SEL_HEN_ICLR,
        SEL_PRIO,
        SEL_STAT_BULK,
        SEL_EN_BULK,
        SEL_CHMAP,
        SEL_POL,
        SEL_TYPE,
        SEL_HEN
    } reg_sel_e;

endpackage

// File: rtl/cpic_srcs.sv
module cpic_srcs #(
    parameter int NUM_SRC = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_SRC-1:0] pol_i,
    input  logic [NUM_SRC-1:0] typ_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] status_o
);

    logic [NUM_SRC-1:0] cond;
    logic [NUM_SRC-1:0] cond_q;
    logic [NUM_SRC-1:0] status_q;
    logic [NUM_SRC-1:0] status_d;
    logic               past_ok;

    // polarity 1 keeps the input, polarity 0 inverts it
    assign cond = ~(src_i ^ pol_i);

    always_comb begin
        for (int s = 0; s < NUM_SRC; s++) begin
            if (typ_i[s]) begin
                status_d[s] = (status_q[s] & ~clr_i[s]) | (cond[s] & ~cond_q[s]);
            end else begin
                status_d[s] = cond[s];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cond_q   <= '0;
            status_q <= '0;
            past_ok  <= 1'b0;
        end else begin
            cond_q   <= cond;
            status_q <= status_d;
            past_ok  <= 1'b1;
        end
    end

    assign status_o = status_q;

    // R4: a latched edge bit stays set unless cleared
    assert_edge_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((status_q & $past(status_q & typ_i & ~clr_i)) == $past(status_q & typ_i & ~clr_i)));

    // R5: level bits mirror the conditioned input of the previous cycle
    assert_level_track_R5: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((status_q & ~$past(typ_i)) == ($past(cond) & ~$past(typ_i))));

endmodule

// File: rtl/cpic_arb.sv
module cpic_arb #(
    parameter int NUM_SRC  = 64,
    parameter int NUM_CHAN = 32,
    localparam int SRC_W   = $clog2(NUM_SRC),
    localparam int CH_W    = $clog2(NUM_CHAN)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_SRC-1:0]            pending_i,
    input  logic [NUM_SRC-1:0][CH_W-1:0]  chan_i,
    output logic [SRC_W-1:0]              win_idx_o,
    output logic                          win_none_o,
    output logic                          fast_any_o,
    output logic                          norm_any_o
);

    logic [CH_W-1:0]  best_ch;
    logic [SRC_W-1:0] best_idx;
    logic             found;

    // strict less-than keeps the lowest source number on a channel tie
    always_comb begin
        best_ch  = '1;
        best_idx = '0;
        found    = 1'b0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (pending_i[s] && (!found || (chan_i[s] < best_ch))) begin
                found    = 1'b1;
                best_ch  = chan_i[s];
                best_idx = SRC_W'(s);
            end
        end
    end

    always_comb begin
        fast_any_o = 1'b0;
        norm_any_o = 1'b0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (pending_i[s]) begin
                if (chan_i[s][CH_W-1:1] == '0) begin
                    fast_any_o = 1'b1;
                end else begin
                    norm_any_o = 1'b1;
                end
            end
        end
    end

    assign win_idx_o  = best_idx;
    assign win_none_o = ~found;

    // R8: a reported winner is always pending
    assert_winner_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !win_none_o |-> pending_i[win_idx_o]);

    // R9: the empty flag means no source is pending
    assert_none_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        win_none_o |-> (pending_i == '0));

    // R10: a pending fast-channel source outranks every normal one
    assert_fast_outranks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fast_any_o |-> (chan_i[win_idx_o][CH_W-1:1] == '0));

endmodule

// File: rtl/cpic_regs.sv
module cpic_regs
    import cpic_pkg::*;
#(
    parameter int NUM_SRC  = 64,
    parameter int NUM_CHAN = 32,
    parameter int ADDR_W   = 13,
    localparam int SRC_W   = $clog2(NUM_SRC),
    localparam int CH_W    = $clog2(NUM_CHAN),
    localparam int NWORD   = (NUM_SRC + 31) / 32,
    localparam int NMAP    = (NUM_SRC + 3) / 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [31:0]                   bus_wdata,
    input  logic                          bus_wr,
    input  logic                          bus_rd,
    output logic [31:0]                   bus_rdata,
    input  logic [NUM_SRC-1:0]            status_i,
    input  logic [SRC_W-1:0]              win_idx_i,
    input  logic                          win_none_i,
    output logic                          glb_en_o,
    output logic [HOST_LINES-1:0]         host_en_o,
    output logic [NUM_SRC-1:0]            sys_en_o,
    output logic [NUM_SRC-1:0]            pol_o,
    output logic [NUM_SRC-1:0]            typ_o,
    output logic [NUM_SRC-1:0][CH_W-1:0]  chan_o,
    output logic [NUM_SRC-1:0]            stat_clr_o
);

    reg_sel_e                      sel;
    int                            widx;
    logic [31:0]                   word_addr;
    logic [31:0]                   rd_next;
    logic                          glb_q;
    logic [HOST_LINES-1:0]         hen_q;
    logic [NUM_SRC-1:0]            en_q;
    logic [NUM_SRC-1:0]            pol_q;
    logic [NUM_SRC-1:0]            typ_q;
    logic [NUM_SRC-1:0][CH_W-1:0]  chan_q;

    assign word_addr = {{(32-ADDR_W){1'b0}}, bus_addr[ADDR_W-1:2], 2'b00};

    always_comb begin
        sel  = SEL_NONE;
        widx = 0;
        if (word_addr == OFF_GLB) begin
            sel = SEL_GLB;
        end else if (word_addr == OFF_STAT_ICLR) begin
            sel = SEL_STAT_ICLR;
        end else if (word_addr == OFF_EN_ISET) begin
            sel = SEL_EN_ISET;
        end else if (word_addr == OFF_EN_ICLR) begin
            sel = SEL_EN_ICLR;
        end else if (word_addr == OFF_HEN_ISET) begin
            sel = SEL_HEN_ISET;
        end else if (word_addr == OFF_HEN_ICLR) begin
            sel = SEL_HEN_ICLR;
        end else if (word_addr == OFF_PRIO) begin
            sel = SEL_PRIO;
        end else if (word_addr == OFF_HEN) begin
            sel = SEL_HEN;
        end else if (word_addr >= OFF_STAT_BULK && word_addr < OFF_STAT_BULK + 32'(4 * NWORD)) begin
            sel  = SEL_STAT_BULK;
            widx = int'((word_addr - OFF_STAT_BULK) >> 2);
        end else if (word_addr >= OFF_EN_BULK && word_addr < OFF_EN_BULK + 32'(4 * NWORD)) begin
            sel  = SEL_EN_BULK;
            widx = int'((word_addr - OFF_EN_BULK) >> 2);
        end else if (word_addr >= OFF_CHMAP && word_addr < OFF_CHMAP + 32'(4 * NMAP)) begin
            sel  = SEL_CHMAP;
            widx = int'((word_addr - OFF_CHMAP) >> 2);
        end else if (word_addr >= OFF_POL && word_addr < OFF_POL + 32'(4 * NWORD)) begin
            sel  = SEL_POL;
            widx = int'((word_addr - OFF_POL) >> 2);
        end else if (word_addr >= OFF_TYPE && word_addr < OFF_TYPE + 32'(4 * NWORD)) begin
            sel  = SEL_TYPE;
            widx = int'((word_addr - OFF_TYPE) >> 2);
        end
    end

    // status clears: indexed word or write-one-to-clear bulk word
    always_comb begin
        for (int s = 0; s < NUM_SRC; s++) begin
            stat_clr_o[s] = bus_wr &&
                (((sel == SEL_STAT_ICLR) && (bus_wdata == 32'(s))) ||
                 ((sel == SEL_STAT_BULK) && (widx == s / 32) && bus_wdata[s % 32]));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            glb_q  <= 1'b0;
            hen_q  <= '0;
            en_q   <= '0;
            pol_q  <= '0;
            typ_q  <= '0;
            chan_q <= '0;
        end else if (bus_wr) begin
            unique case (sel)
                SEL_GLB:  glb_q <= bus_wdata[0];
                SEL_HEN:  hen_q <= bus_wdata[HOST_LINES-1:0];
                SEL_HEN_ISET: begin
                    for (int h = 0; h < HOST_LINES; h++) begin
                        if (bus_wdata == 32'(h)) hen_q[h] <= 1'b1;
                    end
                end
                SEL_HEN_ICLR: begin
                    for (int h = 0; h < HOST_LINES; h++) begin
                        if (bus_wdata == 32'(h)) hen_q[h] <= 1'b0;
                    end
                end
                SEL_EN_ISET: begin
                    for (int s = 0; s < NUM_SRC; s++) begin
                        if (bus_wdata == 32'(s)) en_q[s] <= 1'b1;
                    end
                end
                SEL_EN_ICLR: begin
                    for (int s = 0; s < NUM_SRC; s++) begin
                        if (bus_wdata == 32'(s)) en_q[s] <= 1'b0;
                    end
                end
                SEL_EN_BULK: begin
                    for (int s = 0; s < NUM_SRC; s++) begin
                        if ((widx == s / 32) && bus_wdata[s % 32]) en_q[s] <= 1'b0;
                    end
                end
                SEL_POL: begin
                    for (int s = 0; s < NUM_SRC; s++) begin
                        if (widx == s / 32) pol_q[s] <= bus_wdata[s % 32];
                    end
                end
                SEL_TYPE: begin
                    for (int s = 0; s < NUM_SRC; s++) begin
                        if (widx == s / 32) typ_q[s] <= bus_wdata[s % 32];
                    end
                end
                SEL_CHMAP: begin
                    for (int s = 0; s < NUM_SRC; s++) begin
                        if (widx == s / 4) chan_q[s] <= bus_wdata[(s % 4) * 8 +: CH_W];
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_next = '0;
        unique case (sel)
            SEL_GLB:  rd_next[0] = glb_q;
            SEL_HEN:  rd_next[HOST_LINES-1:0] = hen_q;
            SEL_PRIO: begin
                rd_next[31] = win_none_i;
                if (!win_none_i) rd_next[SRC_W-1:0] = win_idx_i;
            end
            SEL_STAT_BULK: begin
                for (int s = 0; s < NUM_SRC; s++) begin
                    if (widx == s / 32) rd_next[s % 32] = status_i[s];
                end
            end
            SEL_EN_BULK: begin
                for (int s = 0; s < NUM_SRC; s++) begin
                    if (widx == s / 32) rd_next[s % 32] = en_q[s];
                end
            end
            SEL_POL: begin
                for (int s = 0; s < NUM_SRC; s++) begin
                    if (widx == s / 32) rd_next[s % 32] = pol_q[s];
                end
            end
            SEL_TYPE: begin
                for (int s = 0; s < NUM_SRC; s++) begin
                    if (widx == s / 32) rd_next[s % 32] = typ_q[s];
                end
            end
            SEL_CHMAP: begin
                for (int s = 0; s < NUM_SRC; s++) begin
                    if (widx == s / 4) rd_next[(s % 4) * 8 +: CH_W] = chan_q[s];
                end
            end
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_next;
        end
    end

    assign glb_en_o  = glb_q;
    assign host_en_o = hen_q;
    assign sys_en_o  = en_q;
    assign pol_o     = pol_q;
    assign typ_o     = typ_q;
    assign chan_o    = chan_q;

    // R2: an in-range indexed set turns that enable on
    assert_index_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (sel == SEL_EN_ISET) && (bus_wdata < 32'(NUM_SRC)))
        |=> en_q[$past(bus_wdata[SRC_W-1:0])]);

endmodule

// File: rtl/cpic_intc.sv
module cpic_intc
    import cpic_pkg::*;
#(
    parameter int NUM_SRC  = 64,
    parameter int NUM_CHAN = 32,
    parameter int ADDR_W   = 13,
    localparam int SRC_W   = $clog2(NUM_SRC),
    localparam int CH_W    = $clog2(NUM_CHAN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    input  logic               bus_wr,
    input  logic               bus_rd,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_SRC-1:0] src_i,
    output logic               fiq_o,
    output logic               irq_o
);

    logic                          glb_en;
    logic [HOST_LINES-1:0]         host_en;
    logic [NUM_SRC-1:0]            sys_en;
    logic [NUM_SRC-1:0]            pol;
    logic [NUM_SRC-1:0]            typ;
    logic [NUM_SRC-1:0][CH_W-1:0]  chan;
    logic [NUM_SRC-1:0]            stat_clr;
    logic [NUM_SRC-1:0]            status;
    logic [NUM_SRC-1:0]            pending;
    logic [SRC_W-1:0]              win_idx;
    logic                          win_none;
    logic                          fast_any;
    logic                          norm_any;

    cpic_regs #(
        .NUM_SRC  (NUM_SRC),
        .NUM_CHAN (NUM_CHAN),
        .ADDR_W   (ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_rdata  (bus_rdata),
        .status_i   (status),
        .win_idx_i  (win_idx),
        .win_none_i (win_none),
        .glb_en_o   (glb_en),
        .host_en_o  (host_en),
        .sys_en_o   (sys_en),
        .pol_o      (pol),
        .typ_o      (typ),
        .chan_o     (chan),
        .stat_clr_o (stat_clr)
    );

    cpic_srcs #(
        .NUM_SRC (NUM_SRC)
    ) u_srcs (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (src_i),
        .pol_i    (pol),
        .typ_i    (typ),
        .clr_i    (stat_clr),
        .status_o (status)
    );

    assign pending = status & sys_en;

    cpic_arb #(
        .NUM_SRC  (NUM_SRC),
        .NUM_CHAN (NUM_CHAN)
    ) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .pending_i  (pending),
        .chan_i     (chan),
        .win_idx_o  (win_idx),
        .win_none_o (win_none),
        .fast_any_o (fast_any),
        .norm_any_o (norm_any)
    );

    assign fiq_o = glb_en & host_en[0] & fast_any;
    assign irq_o = glb_en & host_en[1] & norm_any;

    // R10: a raised host line always has a source behind it
    assert_line_backed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fiq_o || irq_o) |-> !win_none);

endmodule

// File: tb/cpic_intc_test.sv
`timescale 1ns/1ps
module cpic_intc_test;

    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [12:0] bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_wr;
    logic        bus_rd;
    logic [31:0] bus_rdata;
    logic [N-1:0] src;
    logic        fiq;
    logic        irq;

    always #4 clk = ~clk;

    cpic_intc uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .src_i     (src),
        .fiq_o     (fiq),
        .irq_o     (irq)
    );

    // behavioural reference state
    bit          m_glb;
    bit [1:0]    m_hen;
    bit          m_en   [N];
    bit          m_st   [N];
    bit          m_pol  [N];
    bit          m_typ  [N];
    bit          m_prev [N];
    int          m_ch   [N];
    bit          exp_valid;
    logic [31:0] exp_rd;
    string       cur_req = "R1";
    int          vectors = 0;
    int          miss = 0;
    bit          done = 0;

    function automatic int win(output bit none);
        int best = -1;
        int key  = 0;
        for (int i = 0; i < N; i++) begin
            if (m_st[i] && m_en[i] && (best < 0 || m_ch[i] * 128 + i < key)) begin
                best = i;
                key  = m_ch[i] * 128 + i;
            end
        end
        none = (best < 0);
        return (best < 0) ? 0 : best;
    endfunction

    function automatic logic [31:0] m_read(int a);
        logic [31:0] r = '0;
        bit none;
        int w;
        a = a & ~3;
        if (a == 'h10) r[0] = m_glb;
        else if (a == 'h1500) r[1:0] = m_hen;
        else if (a == 'h80) begin
            w = win(none);
            r = none ? 32'h8000_0000 : 32'(w);
        end else if (a >= 'h280 && a < 'h288) begin
            for (int b = 0; b < 32; b++) r[b] = m_st[(a - 'h280) * 8 + b];
        end else if (a >= 'h380 && a < 'h388) begin
            for (int b = 0; b < 32; b++) r[b] = m_en[(a - 'h380) * 8 + b];
        end else if (a >= 'hD00 && a < 'hD08) begin
            for (int b = 0; b < 32; b++) r[b] = m_pol[(a - 'hD00) * 8 + b];
        end else if (a >= 'hD80 && a < 'hD88) begin
            for (int b = 0; b < 32; b++) r[b] = m_typ[(a - 'hD80) * 8 + b];
        end else if (a >= 'h400 && a < 'h440) begin
            for (int j = 0; j < 4; j++) r[j*8 +: 8] = 8'(m_ch[(a - 'h400) + j]);
        end
        return r;
    endfunction

    function automatic bit m_clr(int i, int a, logic [31:0] d);
        a = a & ~3;
        if (a == 'h24 && d == 32'(i)) return 1;
        if (a == 'h280 + 4 * (i / 32) && d[i % 32]) return 1;
        return 0;
    endfunction

    function automatic void m_write(int a, logic [31:0] d);
        a = a & ~3;
        if (a == 'h10) m_glb = d[0];
        else if (a == 'h28 && d < N) m_en[d] = 1;
        else if (a == 'h2C && d < N) m_en[d] = 0;
        else if (a == 'h34 && d < 2) m_hen[d[0]] = 1;
        else if (a == 'h38 && d < 2) m_hen[d[0]] = 0;
        else if (a == 'h1500) m_hen = d[1:0];
        else if (a >= 'h380 && a < 'h388) begin
            for (int b = 0; b < 32; b++) if (d[b]) m_en[(a - 'h380) * 8 + b] = 0;
        end else if (a >= 'hD00 && a < 'hD08) begin
            for (int b = 0; b < 32; b++) m_pol[(a - 'hD00) * 8 + b] = d[b];
        end else if (a >= 'hD80 && a < 'hD88) begin
            for (int b = 0; b < 32; b++) m_typ[(a - 'hD80) * 8 + b] = d[b];
        end else if (a >= 'h400 && a < 'h440) begin
            for (int j = 0; j < 4; j++) m_ch[(a - 'h400) + j] = int'(d[j*8 +: 5]);
        end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_glb = 0; m_hen = 0; exp_valid = 0;
            for (int i = 0; i < N; i++) begin
                m_en[i] = 0; m_st[i] = 0; m_pol[i] = 0; m_typ[i] = 0;
                m_prev[i] = 0; m_ch[i] = 0;
            end
        end else begin
            exp_valid = bus_rd;
            if (bus_rd) exp_rd = m_read(int'(bus_addr));
            for (int i = 0; i < N; i++) begin
                bit c;
                bit clr;
                c   = m_pol[i] ? src[i] : !src[i];
                clr = bus_wr && m_clr(i, int'(bus_addr), bus_wdata);
                if (m_typ[i]) begin
                    if (c && !m_prev[i]) m_st[i] = 1;
                    else if (clr) m_st[i] = 0;
                end else begin
                    m_st[i] = c;
                end
                m_prev[i] = c;
            end
            if (bus_wr) m_write(int'(bus_addr), bus_wdata);
        end
    end

    // compare away from the active edge, on every clock
    always @(negedge clk) begin
        if (!done) begin
            bit ef;
            bit ei;
            bit none;
            int w;
            ef = 0; ei = 0;
            for (int i = 0; i < N; i++) begin
                if (m_st[i] && m_en[i]) begin
                    if (m_ch[i] < 2) ef = 1; else ei = 1;
                end
            end
            ef = ef && m_glb && m_hen[0];
            ei = ei && m_glb && m_hen[1];
            w = win(none);
            vectors++;
            if (fiq !== ef || irq !== ei) begin
                miss++;
                $display("FAIL %s lines actual fiq=%0b irq=%0b expected fiq=%0b irq=%0b",
                         cur_req, fiq, irq, ef, ei);
            end
            if (exp_valid) begin
                vectors++;
                if (bus_rdata !== exp_rd) begin
                    miss++;
                    $display("FAIL %s read actual=%08h expected=%08h", cur_req, bus_rdata, exp_rd);
                end
            end
        end
    end

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        bus_addr = 13'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(int a);
        @(negedge clk);
        bus_addr = 13'(a); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic setsrc(int i, bit v);
        @(negedge clk);
        src[i] = v;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        miss++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_wr = 0; bus_rd = 0; src = '0;
        idle(3);
        rst_n = 1'b1;

        cur_req = "R1";
        rd('h10); rd('h1500); rd('h380); rd('h384); rd('h80); rd('hD00); rd('h400);

        cur_req = "R6";
        wr('hD00, 32'hA5A5_0F0F); wr('hD84, 32'h0000_0300);
        rd('hD00); rd('hD84); rd('hD80);

        cur_req = "R7";
        wr('h400, 32'h2A03_8107); rd('h400);
        wr('h404, 32'h0000_0400); rd('h404);

        cur_req = "R12";
        rd('h100); rd('h1504); rd('h4);
        wr('h100, 32'hFFFF_FFFF); wr('h4, 32'hFFFF_FFFF);
        rd('h10); rd('h1500); rd('h380);

        cur_req = "R10";
        wr('h10, 1); wr('h34, 0); wr('h34, 1); wr('h34, 7); rd('h1500);

        cur_req = "R4";
        wr('hD00, 32'hA5A5_0F2F); wr('hD80, 32'h0000_0020); wr('h28, 5);
        setsrc(5, 1); idle(2); setsrc(5, 0); idle(3);
        rd('h80); rd('h280);
        wr('h24, 5); idle(2); rd('h80);
        wr('h28, 40);
        setsrc(40, 1); idle(2); setsrc(40, 0); idle(3);
        rd('h284); rd('h80);
        wr('h284, 32'h0000_0100); idle(2); rd('h284);

        cur_req = "R5";
        wr('h408, 32'h0002_0000); wr('h28, 10);
        setsrc(10, 1); idle(2); rd('h280);
        wr('h24, 10); idle(1); rd('h280);
        wr('h280, 32'h0000_0400); rd('h280);
        setsrc(10, 0); idle(2); rd('h280);

        cur_req = "R10";
        wr('h28, 1); setsrc(1, 1); setsrc(10, 1); idle(2); rd('h80);
        wr('h38, 0); idle(2);
        wr('h38, 1); idle(2);
        wr('h1500, 3); idle(2);

        cur_req = "R11";
        wr('h10, 0); idle(3); rd('h80);
        wr('h10, 1); idle(2);

        cur_req = "R8";
        setsrc(1, 0); wr('h2C, 1); setsrc(10, 0);
        wr('h40C, 32'h0000_0303); wr('h414, 32'h0000_0006);
        wr('hD00, 32'hA5A5_3F2F);
        wr('h28, 12); wr('h28, 13); wr('h28, 20);
        setsrc(12, 1); setsrc(13, 1); idle(2);
        rd('h80);
        wr('h2C, 12); rd('h80);

        cur_req = "R3";
        wr('h380, 32'h0000_2000); rd('h80); rd('h380);

        cur_req = "R2";
        wr('h28, 64); rd('h380); rd('h384);
        wr('h28, 63); rd('h384);
        wr('h2C, 63); rd('h384);
        wr('h2C, 200); rd('h380);

        cur_req = "R9";
        wr('h380, 32'hFFFF_FFFF); wr('h384, 32'hFFFF_FFFF);
        rd('h80); rd('h380);

        idle(4);
        finish_run();
    end

endmodule